// File: doc/BRIEF.md
# Compare-Match Up-Counter Timer

This block is a free-running up-counter whose period is set by a compare register. Software reaches it through a byte-addressed register port and can make 1-byte or 2-byte accesses. Once counting is enabled, the counter starts at zero and advances by one on every cycle where `tick_i` is high. When the count reaches the value held in compare register A, the block raises `period_o` for one cycle and the count starts again from zero. A second compare register, B, marks a point inside the period: when the count reaches B, `match_b_o` pulses.

The running count can be read back at any time. While the timer is stopped the count reads as zero. Two compare-mode bytes are kept as plain storage so that software can read them back. Any access the block does not accept raises `bus_err_o` in the same cycle and changes nothing.

Top module: `upcnt_cmp_timer`

## Requirements
- R1: After reset every register and the count are zero, and `period_o`, `match_b_o` and `bus_err_o` are low.
- R2: Mode low byte (offset 0x85): bit 7 enables counting, bit 6 is a stored load flag, and bits 2:0 are reserved. In the mode high byte (offset 0x84), bits 5, 3 and 2 are reserved. A 2-byte access at 0x84 maps byte 0x84 to data bits 15:8 and byte 0x85 to bits 7:0.
- R3: A write that sets a reserved mode bit, or sets enable and load together, raises `bus_err_o` in that cycle and leaves every register unchanged.
- R4: `bus_wide_i`=1 selects a 2-byte access. Compare A (0xC4), compare B (0xD4), the count (0xA4, read only) and the mode register at 0x84 accept both sizes. Mode 0x85 and the compare-mode bytes 0xB4/0xB5 accept 1 byte only. A wrong size, a write to 0xA4 or an unmapped offset raises `bus_err_o` and changes nothing. A 1-byte compare write is zero-extended, and a 1-byte read returns the low byte.
- R5: While enabled and with compare A nonzero, each tick adds one to the count. The tick that brings the count to A pulses `period_o` for one cycle and returns the count to 0, so one period is A ticks.
- R6: When compare A is zero the count does not advance and neither pulse occurs.
- R7: The tick that brings the count to B pulses `match_b_o` for one cycle, but only when 0 < B < A. When B ≥ A, B never pulses.
- R8: Reading offset 0xA4 returns 0 while stopped and the number of ticks since the last restart while running.
- R9: Any accepted write to the mode low byte sets the count to 0 on that edge and ignores a tick in the same cycle. Clearing enable therefore stops the count at 0, and writing enable again restarts it from 0.
- R10: If compare A is lowered to a value at or below the current count, the next tick pulses `period_o` and restarts from 0.
- R11: The compare-mode bytes at 0xB4 and 0xB5 store whatever is written to them and read it back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count tick, one per advance |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 8 | Byte offset of the access |
| bus_wide_i | input | 1 | 1 = 2-byte access, 0 = 1-byte access |
| bus_wdata_i | input | 16 | Write data (1-byte writes use bits 7:0) |
| bus_rdata_o | output | 16 | Read data, combinational, zero when no legal read |
| bus_err_o | output | 1 | Access rejected, same cycle |
| period_o | output | 1 | One-cycle pulse when the count reaches compare A |
| match_b_o | output | 1 | One-cycle pulse when the count reaches compare B |

## Verification
Two functions can land on the same clock edge: a mode write that stops or restarts the counter, and a tick that would complete the period. The bench provokes this by enabling with compare A = 3 and ticks held high, then timing a disable write so that it is captured on the exact edge where the third tick would fire `period_o`. The write must win: no period pulse appears, and the count reads 0 in the next cycle. The same ordering is checked for a re-enable partway through a period, where the scoreboard expects the next pulse one full period after the rewrite and not at the old time.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int BYTE_W = 8;

    // Register offsets; software decodes these, so they are fixed.
    localparam logic [7:0] OFS_MODE_HI = 8'h84;
    localparam logic [7:0] OFS_MODE_LO = 8'h85;
    localparam logic [7:0] OFS_COUNT   = 8'hA4;
    localparam logic [7:0] OFS_CMODE_A = 8'hB4;
    localparam logic [7:0] OFS_CMODE_B = 8'hB5;
    localparam logic [7:0] OFS_CMP_A   = 8'hC4;
    localparam logic [7:0] OFS_CMP_B   = 8'hD4;

    // Mode byte fields
    localparam logic [BYTE_W-1:0] HI_RSVD_MASK = 8'h2C;
    localparam logic [BYTE_W-1:0] LO_RSVD_MASK = 8'h07;
    localparam int RUN_BIT  = 7;
    localparam int LOAD_BIT = 6;

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wide_i,
    input  logic [CNT_W-1:0]  wdata_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic [CNT_W-1:0]  rdata_o,
    output logic              err_o,
    output logic              run_o,
    output logic              restart_o,
    output logic [CNT_W-1:0]  cmp_a_o,
    output logic [CNT_W-1:0]  cmp_b_o
);

    typedef struct packed {
        logic [BYTE_W-1:0] mode_hi;
        logic [BYTE_W-1:0] mode_lo;
        logic [BYTE_W-1:0] cmode_a;
        logic [BYTE_W-1:0] cmode_b;
        logic [CNT_W-1:0]  cmp_a;
        logic [CNT_W-1:0]  cmp_b;
    } regs_t;

    regs_t r_d, r_q;

    logic sel_hi, sel_lo, sel_cnt, sel_cma, sel_cmb, sel_ca, sel_cb;
    logic touch_hi, touch_lo, mapped, size_ok, bad_val, bad, wr_ok;
    logic [BYTE_W-1:0] hi_byte, lo_byte;

    // Decode and legality
    always_comb begin
        sel_hi  = (addr_i == ADDR_W'(OFS_MODE_HI));
        sel_lo  = (addr_i == ADDR_W'(OFS_MODE_LO));
        sel_cnt = (addr_i == ADDR_W'(OFS_COUNT));
        sel_cma = (addr_i == ADDR_W'(OFS_CMODE_A));
        sel_cmb = (addr_i == ADDR_W'(OFS_CMODE_B));
        sel_ca  = (addr_i == ADDR_W'(OFS_CMP_A));
        sel_cb  = (addr_i == ADDR_W'(OFS_CMP_B));

        hi_byte  = wide_i ? wdata_i[2*BYTE_W-1:BYTE_W] : wdata_i[BYTE_W-1:0];
        lo_byte  = wdata_i[BYTE_W-1:0];
        touch_hi = sel_hi;
        touch_lo = sel_lo | (sel_hi & wide_i);

        mapped  = sel_hi | sel_lo | sel_cnt | sel_cma | sel_cmb | sel_ca | sel_cb;
        size_ok = !wide_i | sel_hi | sel_cnt | sel_ca | sel_cb;
        bad_val = wr_en_i &
                  ((touch_hi & (|(hi_byte & HI_RSVD_MASK))) |
                   (touch_lo & ((|(lo_byte & LO_RSVD_MASK)) |
                                (lo_byte[RUN_BIT] & lo_byte[LOAD_BIT]))));
        bad     = !mapped | !size_ok | (wr_en_i & sel_cnt) | bad_val;
        err_o   = (wr_en_i | rd_en_i) & bad;
        wr_ok   = wr_en_i & !bad;
    end

    // Next register state
    always_comb begin
        r_d = r_q;
        if (wr_ok) begin
            if (touch_hi) r_d.mode_hi = hi_byte;
            if (touch_lo) r_d.mode_lo = lo_byte;
            if (sel_cma)  r_d.cmode_a = lo_byte;
            if (sel_cmb)  r_d.cmode_b = lo_byte;
            if (sel_ca)   r_d.cmp_a   = wide_i ? wdata_i : CNT_W'(lo_byte);
            if (sel_cb)   r_d.cmp_b   = wide_i ? wdata_i : CNT_W'(lo_byte);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // Read mux
    always_comb begin
        rdata_o = '0;
        if (rd_en_i && !bad) begin
            if (sel_hi)
                rdata_o = wide_i ? CNT_W'({r_q.mode_hi, r_q.mode_lo}) : CNT_W'(r_q.mode_hi);
            else if (sel_lo)
                rdata_o = CNT_W'(r_q.mode_lo);
            else if (sel_cnt)
                rdata_o = wide_i ? count_i : CNT_W'(count_i[BYTE_W-1:0]);
            else if (sel_cma)
                rdata_o = CNT_W'(r_q.cmode_a);
            else if (sel_cmb)
                rdata_o = CNT_W'(r_q.cmode_b);
            else if (sel_ca)
                rdata_o = wide_i ? r_q.cmp_a : CNT_W'(r_q.cmp_a[BYTE_W-1:0]);
            else if (sel_cb)
                rdata_o = wide_i ? r_q.cmp_b : CNT_W'(r_q.cmp_b[BYTE_W-1:0]);
        end
    end

    assign run_o     = r_q.mode_lo[RUN_BIT];
    assign restart_o = wr_ok & touch_lo;
    assign cmp_a_o   = r_q.cmp_a;
    assign cmp_b_o   = r_q.cmp_b;

    // A rejected write leaves all stored state untouched
    p_reject_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && err_o) |=> $stable(r_q));

    // Mode bytes never hold a reserved bit or enable+load together
    p_mode_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.mode_lo & LO_RSVD_MASK) == '0) &&
        ((r_q.mode_hi & HI_RSVD_MASK) == '0) &&
        !(r_q.mode_lo[RUN_BIT] && r_q.mode_lo[LOAD_BIT]));

endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             run_i,
    input  logic             restart_i,
    input  logic [CNT_W-1:0] cmp_a_i,
    input  logic [CNT_W-1:0] cmp_b_i,
    output logic [CNT_W-1:0] count_o,
    output logic             period_o,
    output logic             match_b_o
);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             period;
        logic             match_b;
    } cnt_state_t;

    cnt_state_t s_d, s_q;
    logic [CNT_W-1:0] nxt;

    always_comb begin
        s_d         = s_q;
        s_d.period  = 1'b0;
        s_d.match_b = 1'b0;
        nxt         = s_q.count + CNT_W'(1);
        if (restart_i || !run_i) begin
            s_d.count = '0;
        end else if (tick_i && (cmp_a_i != '0)) begin
            if (nxt >= cmp_a_i) begin
                s_d.count  = '0;
                s_d.period = 1'b1;
            end else begin
                s_d.count   = nxt;
                s_d.match_b = (nxt == cmp_b_i);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign count_o   = s_q.count;
    assign period_o  = s_q.period;
    assign match_b_o = s_q.match_b;

    p_period_restarts_r5: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.period |-> (s_q.count == '0));

    p_pulse_needs_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.period || s_q.match_b) |-> ($past(tick_i) && $past(run_i)));

    p_stop_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i || restart_i) |=> (s_q.count == '0));

    p_zero_period_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_a_i == '0) |=> (!s_q.period && !s_q.match_b));

    p_match_below_r7: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.match_b |-> (($past(cmp_b_i) < $past(cmp_a_i)) && (s_q.count == $past(cmp_b_i))));

endmodule

// File: rtl/upcnt_cmp_timer.sv
module upcnt_cmp_timer #(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_wide_i,
    input  logic [CNT_W-1:0]  bus_wdata_i,
    output logic [CNT_W-1:0]  bus_rdata_o,
    output logic              bus_err_o,
    output logic              period_o,
    output logic              match_b_o
);

    logic             run;
    logic             restart;
    logic [CNT_W-1:0] cmp_a;
    logic [CNT_W-1:0] cmp_b;
    logic [CNT_W-1:0] count;

    tmr_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (bus_wr_i),
        .rd_en_i   (bus_rd_i),
        .addr_i    (bus_addr_i),
        .wide_i    (bus_wide_i),
        .wdata_i   (bus_wdata_i),
        .count_i   (count),
        .rdata_o   (bus_rdata_o),
        .err_o     (bus_err_o),
        .run_o     (run),
        .restart_o (restart),
        .cmp_a_o   (cmp_a),
        .cmp_b_o   (cmp_b)
    );

    tmr_count #(.CNT_W(CNT_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .run_i     (run),
        .restart_i (restart),
        .cmp_a_i   (cmp_a),
        .cmp_b_i   (cmp_b),
        .count_o   (count),
        .period_o  (period_o),
        .match_b_o (match_b_o)
    );

endmodule

// File: tb/tb_upcnt_cmp_timer.sv
`timescale 1ns/1ps
module tb_upcnt_cmp_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bwr = 1'b0;
    logic        brd = 1'b0;
    logic [7:0]  baddr = '0;
    logic        bwide = 1'b0;
    logic [15:0] bwdata = '0;
    logic [15:0] brdata;
    logic        berr;
    logic        period;
    logic        match_b;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int dummy;
    bit done = 1'b0;

    typedef struct {
        int    at;
        bit    kind;   // 0 = period, 1 = compare-B
        string tag;
    } ev_t;
    ev_t exq[$];

    upcnt_cmp_timer dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick),
        .bus_wr_i(bwr), .bus_rd_i(brd), .bus_addr_i(baddr),
        .bus_wide_i(bwide), .bus_wdata_i(bwdata), .bus_rdata_o(brdata),
        .bus_err_o(berr), .period_o(period), .match_b_o(match_b)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic push(input int at, input bit kind, input string tag);
        ev_t e;
        e.at = at; e.kind = kind; e.tag = tag;
        exq.push_back(e);
    endtask

    // Monitor: every observed pulse must match the head of the queue
    always @(negedge clk) begin : monitor
        ev_t e;
        if (rst_n && (period || match_b)) begin
            checks++;
            if (exq.size() == 0) begin
                errors++;
                $display("FAIL R5 R7: unexpected pulse kind %0d at cycle %0d, expected none",
                         match_b, cyc);
            end else begin
                e = exq.pop_front();
                if (e.at != cyc || e.kind != match_b) begin
                    errors++;
                    $display("FAIL %s: pulse kind %0d at cycle %0d, expected kind %0d at cycle %0d",
                             e.tag, match_b, cyc, e.kind, e.at);
                end
            end
        end
    end

    task automatic wr(input logic [7:0] a, input bit w, input logic [15:0] d,
                      input bit exp_err, input string tag, output int wc);
        wc = cyc;
        baddr = a; bwide = w; bwdata = d; bwr = 1'b1;
        #1 chk(tag, berr, exp_err);
        @(negedge clk);
        bwr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input bit w, input int exp, input string tag);
        baddr = a; bwide = w; brd = 1'b1;
        #1 chk(tag, brdata, exp);
        chk(tag, berr, 0);
        brd = 1'b0;
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic tick_once();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin : driver
        int w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 period", period, 0);
        chk("R1 match", match_b, 0);
        rd(8'h84, 1, 0, "R1 mode");
        rd(8'hA4, 1, 0, "R1 count");
        rd(8'hC4, 1, 0, "R1 cmpA");

        // R4 sizes and zero extension
        wr(8'hC4, 0, 16'h0005, 0, "R4 cmpA byte wr", dummy);
        rd(8'hC4, 1, 16'h0005, "R4 cmpA byte zero-ext");
        wr(8'hC4, 1, 16'h1234, 0, "R4 cmpA wide wr", dummy);
        rd(8'hC4, 1, 16'h1234, "R4 cmpA wide rd");
        rd(8'hC4, 0, 16'h0034, "R4 cmpA byte rd");
        wr(8'hD4, 0, 16'h00AB, 0, "R4 cmpB byte wr", dummy);
        rd(8'hD4, 1, 16'h00AB, "R4 cmpB rd");

        // R2 mode layout
        wr(8'h84, 1, 16'h4140, 0, "R2 mode wide wr", dummy);
        rd(8'h84, 1, 16'h4140, "R2 mode wide rd");
        rd(8'h85, 0, 16'h0040, "R2 low byte");
        rd(8'h84, 0, 16'h0041, "R2 high byte");

        // R11 compare-mode storage
        wr(8'hB4, 0, 16'h005A, 0, "R11 cmodeA wr", dummy);
        wr(8'hB5, 0, 16'h00C3, 0, "R11 cmodeB wr", dummy);
        rd(8'hB4, 0, 16'h005A, "R11 cmodeA rd");
        rd(8'hB5, 0, 16'h00C3, "R11 cmodeB rd");

        // R3 illegal mode values
        wr(8'h85, 0, 16'h00C0, 1, "R3 enable+load", dummy);
        rd(8'h85, 0, 16'h0040, "R3 unchanged lo");
        wr(8'h84, 0, 16'h0004, 1, "R3 hi reserved", dummy);
        rd(8'h84, 0, 16'h0041, "R3 unchanged hi");
        wr(8'h85, 0, 16'h0002, 1, "R3 lo reserved", dummy);
        wr(8'h84, 1, 16'h2080, 1, "R3 wide hi reserved", dummy);
        rd(8'h84, 1, 16'h4140, "R3 unchanged wide");
        rd(8'hA4, 1, 0, "R3 not started");

        // R4 illegal accesses
        wr(8'hB4, 1, 16'h0011, 1, "R4 cmode wide", dummy);
        rd(8'hB4, 0, 16'h005A, "R4 cmode unchanged");
        wr(8'hA4, 0, 16'h0007, 1, "R4 count write", dummy);
        wr(8'h85, 1, 16'h0000, 1, "R4 wide at 0x85", dummy);
        wr(8'h10, 0, 16'h0000, 1, "R4 unmapped", dummy);
        wr(8'h84, 1, 16'h0000, 0, "R2 clear mode", dummy);

        // R5 R7 R8 continuous ticks, A=5, B=3
        wr(8'hC4, 1, 16'd5, 0, "R5 setA", dummy);
        wr(8'hD4, 1, 16'd3, 0, "R7 setB", dummy);
        tick = 1'b1;
        wr(8'h85, 0, 16'h0080, 0, "R5 enable", w);
        for (int k = 0; k < 3; k++) begin
            push(w + 1 + 3 + 5*k, 1'b1, "R7");
            push(w + 1 + 5 + 5*k, 1'b0, "R5");
        end
        wait_until(w + 3);
        rd(8'hA4, 1, 2, "R8 running count");
        wait_until(w + 16);
        wr(8'h85, 0, 16'h0000, 0, "R9 stop", dummy);
        rd(8'hA4, 1, 0, "R9 stopped reads 0");
        tick = 1'b0;

        // R5 gapped ticks, A=3, B=0
        wr(8'hC4, 1, 16'd3, 0, "R5 setA3", dummy);
        wr(8'hD4, 1, 16'd0, 0, "R7 setB0", dummy);
        wr(8'h85, 0, 16'h0080, 0, "R5 enable", dummy);
        repeat (2) @(negedge clk);
        tick_once();
        @(negedge clk);
        tick_once();
        rd(8'hA4, 1, 2, "R8 gapped count");
        rd(8'hA4, 0, 2, "R8 byte count");
        push(cyc + 1, 1'b0, "R5");
        tick_once();
        rd(8'hA4, 1, 0, "R5 wrap to 0");

        // R6 compare A zero
        wr(8'hC4, 1, 16'd0, 0, "R6 setA0", dummy);
        tick = 1'b1;
        repeat (10) @(negedge clk);
        rd(8'hA4, 1, 0, "R6 no advance");
        tick = 1'b0;
        wr(8'h85, 0, 16'h0000, 0, "R6 stop", dummy);

        // R7 B equal to A never pulses
        wr(8'hC4, 1, 16'd4, 0, "R7 setA4", dummy);
        wr(8'hD4, 1, 16'd4, 0, "R7 setB4", dummy);
        tick = 1'b1;
        wr(8'h85, 0, 16'h0080, 0, "R7 enable", w);
        push(w + 5, 1'b0, "R5");
        push(w + 9, 1'b0, "R5");
        wait_until(w + 9);
        wr(8'h85, 0, 16'h0000, 0, "R7 stop", dummy);
        tick = 1'b0;

        // R9 re-enable restarts from 0
        wr(8'hC4, 1, 16'd6, 0, "R9 setA6", dummy);
        wr(8'hD4, 1, 16'd0, 0, "R9 setB0", dummy);
        tick = 1'b1;
        wr(8'h85, 0, 16'h0080, 0, "R9 enable", w);
        wait_until(w + 4);
        rd(8'hA4, 1, 3, "R9 count before restart");
        wr(8'h85, 0, 16'h0080, 0, "R9 re-enable", w);
        push(w + 7, 1'b0, "R9");
        wait_until(w + 8);
        wr(8'h85, 0, 16'h0000, 0, "R9 stop", dummy);
        tick = 1'b0;

        // R9 stop collides with the period-completing tick
        wr(8'hC4, 1, 16'd3, 0, "R9 setA3", dummy);
        tick = 1'b1;
        wr(8'h85, 0, 16'h0080, 0, "R9 enable", w);
        wait_until(w + 3);
        wr(8'h85, 0, 16'h0000, 0, "R9 collide stop", dummy);
        rd(8'hA4, 1, 0, "R9 collide count");
        repeat (4) @(negedge clk);
        tick = 1'b0;

        // R10 lowering A below the count
        wr(8'hC4, 1, 16'd10, 0, "R10 setA10", dummy);
        wr(8'h85, 0, 16'h0080, 0, "R10 enable", dummy);
        for (int i = 0; i < 7; i++) tick_once();
        rd(8'hA4, 1, 7, "R10 count 7");
        wr(8'hC4, 1, 16'd4, 0, "R10 lower A", dummy);
        push(cyc + 1, 1'b0, "R10");
        tick_once();
        rd(8'hA4, 1, 0, "R10 restart");
        wr(8'h85, 0, 16'h0000, 0, "R10 stop", dummy);

        repeat (5) @(negedge clk);
        while (exq.size() > 0) begin
            ev_t e;
            e = exq.pop_front();
            checks++;
            errors++;
            $display("FAIL %s: got no pulse expected kind %0d at cycle %0d", e.tag, e.kind, e.at);
        end
        done = 1'b1;
        summary();
        $finish;
    end

endmodule